// File: doc/BRIEF.md
# Receive Credit Flow Controller

This block manages receive-side credit for a point-to-point channel that carries data in bursts. Each burst needs one buffer at the host. The block keeps three wrapping counters: buffers the host has released, READY credits already sent to the far end, and bursts that have arrived. While a connection is accepted, it sends single-cycle READY pulses until the sent-credit count matches the buffer count. Each arriving burst is either passed on to the host or dropped as an overflow.

The host can load the buffer count directly before a connection, or pulse the release input once per free buffer. When a connection ends, the host picks one of two options. It can clear all the counters. Or it can keep the unused capacity: the sent-credit counter is then loaded from the burst counter, so the capacity still owed is re-offered on the next connection. All counter tests compare the wrapped 16-bit values for equality only, so wraparound is harmless.

Top module: `rx_credit_ctrl`

## Requirements
- R1: After `rst_n` is released, `ready_pulse`, `burst_xfer`, `burst_drop` and `ovf_err` are low, and all three counters are zero.
- R2: Each low-to-high change of `buf_rel` adds exactly one to the buffer count, however long the input then stays high.
- R3: READY pulses go out only while `conn_acc` is high. Each pulse adds one to the sent-credit count. Pulses continue until the sent-credit count equals the buffer count.
- R4: If the buffer count is zero when the connection is accepted, no pulse goes out. Buffers released later during the connection produce one pulse each.
- R5: A release edge is ignored while buffer == burst − 1 (mod 65536). This limits outstanding credit to 65535.
- R6: A burst strobe that arrives while burst ≠ sent-credit adds one to the burst count. It raises `burst_xfer` for one cycle, in the cycle after the strobe.
- R7: A burst strobe that arrives while burst == sent-credit leaves the counters unchanged. It raises `burst_drop` for one cycle, in the cycle after the strobe, and sets `ovf_err`. `ovf_err` then stays set until R8 or R10 applies.
- R8: A cycle with `clr_n` low zeroes all three counters and `ovf_err`.
- R9: Two READY pulses are at least `MIN_GAP` cycles apart (default 2), measured rising edge to rising edge.
- R10: `conn_end` with `keep_cap` low zeroes all three counters and `ovf_err`.
- R11: `conn_end` with `keep_cap` high loads the sent-credit count with the burst count. The next connection then sends buffer − burst pulses. `ovf_err` is unaffected.
- R12: `preload_en` loads the buffer count from `preload_val` only when `link_up` is high and `conn_acc` is low. Otherwise `preload_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low counter and error clear |
| link_up | input | 1 | Far end is physically connected |
| conn_acc | input | 1 | Connection request accepted (level) |
| conn_end | input | 1 | One-cycle end-of-connection event |
| keep_cap | input | 1 | On `conn_end`: 1 keeps capacity, 0 resets counters |
| preload_en | input | 1 | Load the buffer count from `preload_val` |
| preload_val | input | 16 | Buffer count preload value |
| buf_rel | input | 1 | Host buffer-release level; rising edges count |
| burst_in | input | 1 | One-cycle burst-arrival strobe |
| ready_pulse | output | 1 | One-cycle READY credit pulse to the far end |
| burst_xfer | output | 1 | Arriving burst accepted for transfer |
| burst_drop | output | 1 | Arriving burst dropped |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The assertions assume that `burst_in` and `conn_end` are single-cycle strobes and that `conn_acc` falls no later than the `conn_end` cycle. If `conn_acc` stayed high, a pulse from the old connection could be counted as one for the new connection. They also assume that host inputs are already synchronous to `clk`, so every edge seen at a clock edge is a real event. The stimulus changes every input on the falling clock edge. It raises each strobe for exactly one cycle, and it lowers `conn_acc` in the same cycle it raises `conn_end`. The one case that reaches the cap is entered through a legal preload made while disconnected.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t cnt_next(cnt_t v);
    return v + cnt_t'(1);
  endfunction

  // buffer sits one step behind the burst count (mod 2^CNT_W)
  function automatic logic buf_at_cap(cnt_t b, cnt_t s);
    return cnt_next(b) == s;
  endfunction

  function automatic logic credit_owed(cnt_t sent, cnt_t bufs);
    return sent != bufs;
  endfunction

  function automatic logic burst_has_credit(cnt_t s, cnt_t sent);
    return s != sent;
  endfunction
endpackage

// File: rtl/rcc_edge_det.sv
module rcc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/rcc_credit_cnt.sv
module rcc_credit_cnt
  import rcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic end_evt,
  input  logic keep_cap,
  input  logic preload_ok,
  input  cnt_t preload_val,
  input  logic rel_rise,
  input  logic ready_fire,
  input  logic burst_in,
  output cnt_t buf_cnt,
  output cnt_t rdy_cnt,
  output cnt_t brst_cnt,
  output logic burst_ok,
  output logic burst_bad
);
  logic quiet;
  logic has_credit;

  assign quiet      = !clr && !end_evt;
  assign has_credit = burst_has_credit(brst_cnt, rdy_cnt);
  assign burst_ok   = quiet && burst_in && has_credit;
  assign burst_bad  = quiet && burst_in && !has_credit;

  // buffer count: preload wins over a release edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         buf_cnt <= '0;
    else if (clr)                       buf_cnt <= '0;
    else if (end_evt) begin
      if (!keep_cap)                    buf_cnt <= '0;
    end
    else if (preload_ok)                buf_cnt <= preload_val;
    else if (rel_rise && !buf_at_cap(buf_cnt, brst_cnt))
                                        buf_cnt <= cnt_next(buf_cnt);
  end

  // sent-credit count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rdy_cnt <= '0;
    else if (clr)                       rdy_cnt <= '0;
    else if (end_evt)                   rdy_cnt <= keep_cap ? brst_cnt : '0;
    else if (ready_fire)                rdy_cnt <= cnt_next(rdy_cnt);
  end

  // burst count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         brst_cnt <= '0;
    else if (clr)                       brst_cnt <= '0;
    else if (end_evt) begin
      if (!keep_cap)                    brst_cnt <= '0;
    end
    else if (burst_ok)                  brst_cnt <= cnt_next(brst_cnt);
  end
endmodule

// File: rtl/rcc_ready_gen.sv
module rcc_ready_gen #(
  parameter int MIN_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conn_acc,
  input  logic owed,
  input  logic hold,
  output logic ready_fire,
  output logic ready_pulse
);
  localparam int GAP_W = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_GAP - 1);

  logic [GAP_W-1:0] gap_cnt;
  logic             gap_open;

  assign gap_open   = (gap_cnt == '0);
  assign ready_fire = conn_acc && owed && !hold && gap_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt     <= '0;
      ready_pulse <= 1'b0;
    end else begin
      ready_pulse <= ready_fire;
      if (ready_fire)      gap_cnt <= GAP_LOAD;
      else if (!gap_open)  gap_cnt <= gap_cnt - GAP_W'(1);
    end
  end
endmodule

// File: rtl/rx_credit_ctrl.sv
module rx_credit_ctrl
  import rcc_pkg::*;
#(
  parameter int MIN_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             link_up,
  input  logic             conn_acc,
  input  logic             conn_end,
  input  logic             keep_cap,
  input  logic             preload_en,
  input  logic [CNT_W-1:0] preload_val,
  input  logic             buf_rel,
  input  logic             burst_in,
  output logic             ready_pulse,
  output logic             burst_xfer,
  output logic             burst_drop,
  output logic             ovf_err
);
  // named internal events
  logic clr;
  logic rel_rise;
  logic preload_ok;
  logic ready_fire;
  logic owed;
  logic burst_ok;
  logic burst_bad;
  logic err_wipe;
  cnt_t buf_cnt;
  cnt_t rdy_cnt;
  cnt_t brst_cnt;

  assign clr        = !clr_n;
  assign preload_ok = preload_en && link_up && !conn_acc;
  assign owed       = credit_owed(rdy_cnt, buf_cnt);
  assign err_wipe   = clr || (conn_end && !keep_cap);

  rcc_edge_det u_rel_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (buf_rel),
    .rise  (rel_rise)
  );

  rcc_credit_cnt u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .end_evt     (conn_end),
    .keep_cap    (keep_cap),
    .preload_ok  (preload_ok),
    .preload_val (preload_val),
    .rel_rise    (rel_rise),
    .ready_fire  (ready_fire),
    .burst_in    (burst_in),
    .buf_cnt     (buf_cnt),
    .rdy_cnt     (rdy_cnt),
    .brst_cnt    (brst_cnt),
    .burst_ok    (burst_ok),
    .burst_bad   (burst_bad)
  );

  rcc_ready_gen #(.MIN_GAP(MIN_GAP)) u_rdy (
    .clk         (clk),
    .rst_n       (rst_n),
    .conn_acc    (conn_acc),
    .owed        (owed),
    .hold        (clr || conn_end),
    .ready_fire  (ready_fire),
    .ready_pulse (ready_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_xfer <= 1'b0;
      burst_drop <= 1'b0;
      ovf_err    <= 1'b0;
    end else begin
      burst_xfer <= burst_ok;
      burst_drop <= burst_bad;
      if (err_wipe)       ovf_err <= 1'b0;
      else if (burst_bad) ovf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
  import rcc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic clr_n,
  input logic link_up,
  input logic conn_acc,
  input logic conn_end,
  input logic keep_cap,
  input logic preload_en,
  input logic ready_pulse,
  input logic burst_xfer,
  input logic burst_drop,
  input logic ovf_err,
  input cnt_t buf_cnt,
  input cnt_t rdy_cnt,
  input cnt_t brst_cnt
);
  AST_PULSE_NEEDS_CONN: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |-> $past(conn_acc)); // R3

  AST_PULSE_STEPS_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |-> rdy_cnt == cnt_next($past(rdy_cnt))); // R3

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |=> !ready_pulse); // R9

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_xfer && burst_drop)); // R6

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_drop |-> ovf_err); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && clr_n && !conn_end) |=> ovf_err); // R7

  AST_BUF_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !conn_end && !(preload_en && link_up && !conn_acc)
     && cnt_next(buf_cnt) == brst_cnt) |=> buf_cnt == $past(buf_cnt)); // R5

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (buf_cnt == '0 && rdy_cnt == '0 && brst_cnt == '0 && !ovf_err)); // R8

  AST_END_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_end && clr_n && !keep_cap) |=>
      (buf_cnt == '0 && rdy_cnt == '0 && brst_cnt == '0 && !ovf_err)); // R10

  AST_END_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_end && clr_n && keep_cap) |=> rdy_cnt == $past(brst_cnt)); // R11
endmodule

bind rx_credit_ctrl rcc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_n       (clr_n),
  .link_up     (link_up),
  .conn_acc    (conn_acc),
  .conn_end    (conn_end),
  .keep_cap    (keep_cap),
  .preload_en  (preload_en),
  .ready_pulse (ready_pulse),
  .burst_xfer  (burst_xfer),
  .burst_drop  (burst_drop),
  .ovf_err     (ovf_err),
  .buf_cnt     (buf_cnt),
  .rdy_cnt     (rdy_cnt),
  .brst_cnt    (brst_cnt)
);

// File: tb/rx_credit_ctrl_tb_top.sv
module rx_credit_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_GAP    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1;
  logic        link_up = 1'b1;
  logic        conn_acc = 1'b0;
  logic        conn_end = 1'b0;
  logic        keep_cap = 1'b0;
  logic        preload_en = 1'b0;
  logic [15:0] preload_val = '0;
  logic        buf_rel = 1'b0;
  logic        burst_in = 1'b0;
  logic        ready_pulse, burst_xfer, burst_drop, ovf_err;

  rx_credit_ctrl #(.MIN_GAP(MIN_GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .link_up(link_up),
    .conn_acc(conn_acc), .conn_end(conn_end), .keep_cap(keep_cap),
    .preload_en(preload_en), .preload_val(preload_val), .buf_rel(buf_rel),
    .burst_in(burst_in), .ready_pulse(ready_pulse), .burst_xfer(burst_xfer),
    .burst_drop(burst_drop), .ovf_err(ovf_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef enum logic {EXP_XFER, EXP_DROP} verdict_e;
  verdict_e exp_q[$];

  int checks = 0;
  int fails = 0;
  int pulse_total = 0;
  int cyc = 0;
  int last_pulse = -1000;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: pulse spacing and burst verdict scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ready_pulse) begin
        pulse_total++;
        if (cyc - last_pulse < MIN_GAP)
          chk(1'b0, "R9", "pulse spacing", cyc - last_pulse, MIN_GAP);
        last_pulse = cyc;
      end
      if (burst_xfer || burst_drop) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected burst verdict", int'(burst_drop), -1);
        end else begin
          verdict_e e;
          e = exp_q.pop_front();
          chk(burst_drop == (e == EXP_DROP) && burst_xfer == (e == EXP_XFER),
              (e == EXP_DROP) ? "R7" : "R6", "burst verdict drop",
              int'(burst_drop), int'(e == EXP_DROP));
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_buf(input int n);
    for (int i = 0; i < n; i++) begin
      buf_rel = 1'b1; tick(3);
      buf_rel = 1'b0; tick(1);
    end
  endtask

  task automatic send_burst(input verdict_e e);
    exp_q.push_back(e);
    burst_in = 1'b1; tick(1);
    burst_in = 1'b0; tick(2);
  endtask

  task automatic wait_quiet();
    int idle = 0;
    while (idle < 12) begin
      tick(1);
      if (ready_pulse) idle = 0;
      else idle++;
    end
  endtask

  task automatic end_conn(input logic keep);
    conn_end = 1'b1; keep_cap = keep; conn_acc = 1'b0;
    tick(1);
    conn_end = 1'b0; keep_cap = 1'b0;
    tick(2);
  endtask

  task automatic preload(input logic [15:0] v);
    preload_val = v; preload_en = 1'b1; tick(1);
    preload_en = 1'b0; tick(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R3", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int p0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk(!ready_pulse && !burst_xfer && !burst_drop, "R1", "outputs idle",
        int'(ready_pulse), 0);
    chk(!ovf_err, "R1", "ovf_err after reset", int'(ovf_err), 0);

    // R4: connect with no buffers
    p0 = pulse_total; conn_acc = 1'b1; tick(20);
    chk(pulse_total == p0, "R4", "pulses with zero buffers", pulse_total - p0, 0);
    // R4, R2: later releases (held 3 cycles each) -> one pulse each
    p0 = pulse_total; release_buf(3); wait_quiet();
    chk(pulse_total - p0 == 3, "R2", "pulses after 3 held releases", pulse_total - p0, 3);

    // R3: no pulses while not accepted, then they flow
    conn_acc = 1'b0;
    p0 = pulse_total; release_buf(2); tick(10);
    chk(pulse_total == p0, "R3", "pulses while not accepted", pulse_total - p0, 0);
    conn_acc = 1'b1; wait_quiet();
    chk(pulse_total - p0 == 2, "R3", "pulses after accept", pulse_total - p0, 2);

    // R6 / R7: five credits then one overflow
    for (int i = 0; i < 5; i++) send_burst(EXP_XFER);
    send_burst(EXP_DROP);
    chk(ovf_err, "R7", "ovf_err after drop", int'(ovf_err), 1);
    tick(5);
    chk(ovf_err, "R7", "ovf_err sticky", int'(ovf_err), 1);

    // R11: keep capacity: buf=7 sent=7 burst=6 -> one pulse next time
    p0 = pulse_total; release_buf(2); wait_quiet();
    chk(pulse_total - p0 == 2, "R3", "pulses after extra release", pulse_total - p0, 2);
    send_burst(EXP_XFER);
    end_conn(1'b1);
    chk(ovf_err, "R11", "ovf_err kept over keep-end", int'(ovf_err), 1);
    p0 = pulse_total; conn_acc = 1'b1; wait_quiet();
    chk(pulse_total - p0 == 1, "R11", "re-sent credits", pulse_total - p0, 1);

    // R10: reset at end; burst then has no credit
    end_conn(1'b0);
    chk(!ovf_err, "R10", "ovf_err after reset-end", int'(ovf_err), 0);
    p0 = pulse_total; conn_acc = 1'b1; tick(10);
    chk(pulse_total == p0, "R10", "pulses after reset-end", pulse_total - p0, 0);
    send_burst(EXP_DROP); // R10 counters zero -> drop

    // R8: clear input
    p0 = pulse_total; release_buf(2); wait_quiet();
    chk(pulse_total - p0 == 2, "R4", "pulses after release", pulse_total - p0, 2);
    clr_n = 1'b0; tick(1); clr_n = 1'b1; tick(1);
    chk(!ovf_err, "R8", "ovf_err after clear", int'(ovf_err), 0);
    p0 = pulse_total; tick(10);
    chk(pulse_total == p0, "R8", "pulses after clear", pulse_total - p0, 0);
    send_burst(EXP_DROP); // R8 counters zero -> drop

    // R12: preload ignored without link, honoured with it
    conn_acc = 1'b0; link_up = 1'b0; preload(16'd7); link_up = 1'b1;
    p0 = pulse_total; conn_acc = 1'b1; wait_quiet();
    chk(pulse_total == p0, "R12", "pulses after ignored preload", pulse_total - p0, 0);
    conn_acc = 1'b0; preload(16'd4);
    p0 = pulse_total; conn_acc = 1'b1; wait_quiet();
    chk(pulse_total - p0 == 4, "R12", "pulses after preload", pulse_total - p0, 4);

    // R5: cap at burst-1 (burst=0 -> cap 0xFFFF)
    end_conn(1'b0);
    preload(16'hFFFE);
    release_buf(2);
    p0 = pulse_total; conn_acc = 1'b1; wait_quiet();
    chk(pulse_total - p0 == 65535, "R5", "pulses at capacity cap", pulse_total - p0, 65535);
    send_burst(EXP_XFER); // R6 across wrap

    tick(5);
    chk(exp_q.size() == 0, "R6", "verdicts outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule